// File: doc/BRIEF.md
# Three-Level Virtual Address Translation Walker

The walker turns a 39-bit virtual address into a 56-bit physical address by reading up to three 8-byte translation entries through a request/acknowledge memory port. Each level indexes its table with a 9-bit slice of the virtual page number. The walk begins at the top level, using a root table page number supplied with the start request. It ends on a leaf entry, which may be a 4 KiB page, a 2 MiB superpage or a 1 GiB superpage, or it ends on the first fault. A separate permission unit checks the access type against the leaf attributes, taking the privilege and the executable-readable and user-access overrides into account.

When a leaf needs its accessed or dirty flag set, the walker either reports that it needs an update or writes the amended entry back to the same address, depending on an enable sampled with the start request. A write that fails turns into an access fault. Each walk ends with a one-cycle done pulse. On success it also gives the physical address, the final entry, that entry's address, the level where the leaf was found, and a global flag gathered from every entry visited.

Top module: `pt_walker`

## Requirements
- R1: The entry for level L is read from root_or_next_page×4096 + VA[12+9L +: 9]×8, starting at L=2 with root_ppn_i. A request stays asserted with a steady address until mem_ack_i.
- R2: A read acknowledged with mem_err_i ends the walk with err_o=1 (access fault).
- R3: An entry with bit0 (valid)=0, or with bit2 (write)=1 and bit1 (read)=0, ends the walk with err_o=2 (invalid entry).
- R4: An entry with bits 3..1 (execute, write, read) all zero points to the next table. Its PPN (bits 53..10) becomes the next base and the level drops by one. Such an entry at level 0 gives err_o=2.
- R5: Permission, with acc_i 0=read, 1=write, 2=read-write, 3=fetch and user_i 1=user, 0=supervisor. The leaf is readable when R=1, or when X=1 and mxr_i=1. User accesses need bit4 (U)=1. Supervisor data accesses need U=0 or sum_i=1. Supervisor fetch needs U=0. A failure gives err_o=3.
- R6: For a leaf at level L>0, nonzero low 9L PPN bits give err_o=4 (misaligned). Otherwise those bits come from the VPN. paddr_o is {PPN, VA[11:0]} and level_o is L.
- R7: global_o is the OR of bit5 (G) over all entries read in the walk.
- R8: An update is needed when bit6 (A)=0, or when bit7 (D)=0 on a write or read-write access. If upd_en_i was 0 at start, the walk ends with err_o=5.
- R9: If upd_en_i was 1 at start, the entry is written back with A set, plus D for write and read-write. pte_o returns that entry. A write acknowledged with an error gives err_o=1.
- R10: done_o is high for exactly one cycle, the cycle after the final acknowledge, with fault_o=1 exactly when err_o≠0. start_i and changes on vaddr_i during a walk have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 39 | Virtual address |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 read-write, 3 fetch |
| user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| mxr_i | input | 1 | Execute-only pages readable |
| sum_i | input | 1 | Supervisor may touch user data pages |
| upd_en_i | input | 1 | Allow accessed/dirty write-back |
| root_ppn_i | input | 44 | Page number of the top-level table |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 56 | Entry physical address |
| mem_wdata_o | output | 64 | Entry being written back |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_err_i | input | 1 | Acknowledged access failed |
| mem_rdata_i | input | 64 | Entry read data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk failed |
| err_o | output | 3 | 0 none, 1 access, 2 invalid, 3 permission, 4 misaligned, 5 update needed |
| paddr_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Final leaf entry |
| pte_addr_o | output | 56 | Address of the leaf entry |
| level_o | output | 2 | Level of the leaf |
| global_o | output | 1 | Accumulated global flag |

## Verification
The walker spends one cycle per memory access when memory acknowledges in the cycle after a request. Its done pulse and results therefore appear one cycle after the last acknowledge: a 4 KiB walk finishes in 4 cycles after start, a 2 MiB walk in 3, a 1 GiB walk in 2, and a write-back adds one more. The bench runs a responder that answers every request in that next cycle. It counts falling edges from the start edge and compares each count with the number of accesses the scenario calls for, plus one. All outputs are sampled on the falling edge at which done is first seen, and once more on the edge after that, to show that the pulse lasted one cycle and that no further request was made.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RW    = 2'd2,
    ACC_FETCH = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ACCESS   = 3'd1,
    ERR_INVALID  = 3'd2,
    ERR_PERM     = 3'd3,
    ERR_MISALIGN = 3'd4,
    ERR_UPDATE   = 3'd5
  } err_e;

  localparam int ATTR_W = 8;
  localparam int AT_V = 0;
  localparam int AT_R = 1;
  localparam int AT_W = 2;
  localparam int AT_X = 3;
  localparam int AT_U = 4;
  localparam int AT_G = 5;
  localparam int AT_A = 6;
  localparam int AT_D = 7;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic              mxr_i,
  input  logic              sum_i,
  output logic              ok_o
);
  logic rd_ok;
  logic kind_ok;

  always_comb begin
    rd_ok = attr_i[AT_R] | (attr_i[AT_X] & mxr_i);
    case (acc_e'(acc_i))
      ACC_READ:  kind_ok = rd_ok;
      ACC_WRITE: kind_ok = attr_i[AT_W];
      ACC_RW:    kind_ok = rd_ok & attr_i[AT_W];
      default:   kind_ok = attr_i[AT_X];
    endcase
    if (user_i)
      ok_o = kind_ok & attr_i[AT_U];
    else if (acc_i == ACC_FETCH)
      ok_o = kind_ok & ~attr_i[AT_U];
    else
      ok_o = kind_ok & (~attr_i[AT_U] | sum_i);
  end
endmodule

// File: rtl/ptw_adupd.sv
module ptw_adupd
  import ptw_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [1:0]        acc_i,
  output logic              need_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic mark_dirty;

  always_comb begin
    mark_dirty = ((acc_i == ACC_WRITE) || (acc_i == ACC_RW)) && !attr_i[AT_D];
    need_o     = mark_dirty || !attr_i[AT_A];
    attr_o     = attr_i;
    attr_o[AT_A] = 1'b1;
    if (mark_dirty) attr_o[AT_D] = 1'b1;
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf #(
  parameter int PPN_W  = 44,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             misalign_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic [PPN_W-1:0] low_mask;
  logic [PPN_W-1:0] vpn_ext;

  always_comb begin
    low_mask   = ~({PPN_W{1'b1}} << (int'(level_i) * IDX_W));
    vpn_ext    = PPN_W'(vpn_i);
    misalign_o = |(ppn_i & low_mask);
    ppn_o      = (ppn_i & ~low_mask) | (vpn_ext & low_mask);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 39,
  parameter int PA_W    = 56,
  parameter int PTE_W   = 64,
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 9,
  parameter int OFS_W   = 12,
  parameter int PTE_LOG = 3,
  parameter int PPN_LSB = 10,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic              mxr_i,
  input  logic              sum_i,
  input  logic              upd_en_i,
  input  logic [PPN_W-1:0]  root_ppn_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [2:0]        err_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [PTE_W-1:0]  pte_o,
  output logic [PA_W-1:0]   pte_addr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              global_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} st_e;

  st_e              st;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sum_q, upd_q, glob_q;
  logic [PTE_W-1:0] wb_q;
  logic [PA_W-1:0]  ent_q;

  // entry address for the current level
  logic [IDX_W-1:0]  idx;
  logic [PA_W-1:0]   rd_addr;
  logic [ATTR_W-1:0] attr;
  logic [PPN_W-1:0]  ent_ppn;
  logic              glob_n;

  always_comb begin
    idx     = va_q[OFS_W + int'(lvl_q) * IDX_W +: IDX_W];
    rd_addr = {base_q, {OFS_W{1'b0}}} + PA_W'({idx, {PTE_LOG{1'b0}}});
    attr    = mem_rdata_i[ATTR_W-1:0];
    ent_ppn = mem_rdata_i[PPN_LSB +: PPN_W];
    glob_n  = glob_q | attr[AT_G];
  end

  logic              perm_ok, ad_need, misal;
  logic [ATTR_W-1:0] ad_attr;
  logic [PPN_W-1:0]  leaf_ppn;

  ptw_perm u_perm (
    .attr_i(attr), .acc_i(acc_q), .user_i(user_q),
    .mxr_i(mxr_q), .sum_i(sum_q), .ok_o(perm_ok)
  );

  ptw_adupd u_adupd (
    .attr_i(attr), .acc_i(acc_q), .need_o(ad_need), .attr_o(ad_attr)
  );

  ptw_leaf #(.PPN_W(PPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_leaf (
    .ppn_i(ent_ppn), .vpn_i(va_q[OFS_W +: VPN_W]), .level_i(lvl_q),
    .misalign_o(misal), .ppn_o(leaf_ppn)
  );

  // outcome of a read acknowledge, in priority order
  logic rd_fin, rd_down, rd_wb;
  err_e rd_err;

  always_comb begin
    rd_fin  = 1'b1;
    rd_down = 1'b0;
    rd_wb   = 1'b0;
    rd_err  = ERR_NONE;
    if (mem_err_i)
      rd_err = ERR_ACCESS;
    else if (!attr[AT_V] || (attr[AT_W] && !attr[AT_R]))
      rd_err = ERR_INVALID;
    else if (!attr[AT_R] && !attr[AT_W] && !attr[AT_X]) begin
      if (lvl_q == '0) rd_err = ERR_INVALID;
      else begin
        rd_fin  = 1'b0;
        rd_down = 1'b1;
      end
    end
    else if (!perm_ok)
      rd_err = ERR_PERM;
    else if (misal)
      rd_err = ERR_MISALIGN;
    else if (ad_need && !upd_q)
      rd_err = ERR_UPDATE;
    else if (ad_need) begin
      rd_fin = 1'b0;
      rd_wb  = 1'b1;
    end
  end

  assign mem_req_o   = (st != S_IDLE);
  assign mem_we_o    = (st == S_WRITE);
  assign mem_addr_o  = (st == S_WRITE) ? ent_q : rd_addr;
  assign mem_wdata_o = wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      lvl_q      <= '0;
      base_q     <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      user_q     <= 1'b0;
      mxr_q      <= 1'b0;
      sum_q      <= 1'b0;
      upd_q      <= 1'b0;
      glob_q     <= 1'b0;
      wb_q       <= '0;
      ent_q      <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      err_o      <= ERR_NONE;
      paddr_o    <= '0;
      pte_o      <= '0;
      pte_addr_o <= '0;
      level_o    <= '0;
      global_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          va_q   <= vaddr_i;
          acc_q  <= acc_i;
          user_q <= user_i;
          mxr_q  <= mxr_i;
          sum_q  <= sum_i;
          upd_q  <= upd_en_i;
          base_q <= root_ppn_i;
          lvl_q  <= TOP_LVL;
          glob_q <= 1'b0;
          st     <= S_READ;
        end
        S_READ: if (mem_ack_i) begin
          ent_q  <= rd_addr;
          glob_q <= glob_n;
          if (rd_down) begin
            base_q <= ent_ppn;
            lvl_q  <= lvl_q - LVL_W'(1);
          end
          if (rd_err == ERR_NONE && !rd_down) begin
            paddr_o    <= {leaf_ppn, va_q[OFS_W-1:0]};
            pte_addr_o <= rd_addr;
            level_o    <= lvl_q;
            global_o   <= glob_n;
          end
          if (rd_wb) begin
            wb_q <= {mem_rdata_i[PTE_W-1:ATTR_W], ad_attr};
            st   <= S_WRITE;
          end
          if (rd_fin) begin
            if (rd_err == ERR_NONE) pte_o <= mem_rdata_i;
            done_o  <= 1'b1;
            fault_o <= (rd_err != ERR_NONE);
            err_o   <= rd_err;
            st      <= S_IDLE;
          end
        end
        S_WRITE: if (mem_ack_i) begin
          done_o  <= 1'b1;
          fault_o <= mem_err_i;
          err_o   <= mem_err_i ? ERR_ACCESS : ERR_NONE;
          if (!mem_err_i) pte_o <= wb_q;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 56,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [OFS_W-1:0] va_ofs,
  input logic             done_o,
  input logic             fault_o,
  input logic [2:0]       err_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             wb_abit,
  input logic [OFS_W-1:0] pa_ofs
);
  logic             busy_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ofs_q  <= '0;
    end else if (start_i && !(busy_q && !done_o)) begin
      busy_q <= 1'b1;
      ofs_q  <= va_ofs;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_done_after_start: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_q);

  a_r10_req_in_walk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (busy_q && !done_o));

  a_r10_fault_code: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (fault_o == (err_o != 3'd0)));

  a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r9_wb_sets_a: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> wb_abit);

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fault_o) |-> (pa_ofs == ofs_q));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .va_ofs(vaddr_i[OFS_W-1:0]),
  .done_o(done_o), .fault_o(fault_o), .err_o(err_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_ack_i(mem_ack_i),
  .mem_addr_o(mem_addr_o), .wb_abit(mem_wdata_o[6]), .pa_ofs(paddr_o[OFS_W-1:0])
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, user_i, mxr_i, sum_i, upd_en_i;
  logic [38:0] vaddr_i;
  logic [1:0]  acc_i;
  logic [43:0] root_ppn_i;
  logic        mem_req_o, mem_we_o, mem_ack_i, mem_err_i;
  logic [55:0] mem_addr_o, paddr_o, pte_addr_o;
  logic [63:0] mem_wdata_o, mem_rdata_i, pte_o;
  logic        done_o, fault_o, global_o;
  logic [2:0]  err_o;
  logic [1:0]  level_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] store [logic [55:0]];
  logic [55:0] bad_rd, bad_wr;

  localparam logic [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08,
                         U = 8'h10, G = 8'h20, A = 8'h40, D = 8'h80;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .start_i(start_i), .vaddr_i(vaddr_i), .acc_i(acc_i),
    .user_i(user_i), .mxr_i(mxr_i), .sum_i(sum_i), .upd_en_i(upd_en_i),
    .root_ppn_i(root_ppn_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .fault_o(fault_o), .err_o(err_o), .paddr_o(paddr_o), .pte_o(pte_o),
    .pte_addr_o(pte_addr_o), .level_o(level_o), .global_o(global_o)
  );

  // memory: answers each request in the following cycle
  initial begin
    mem_ack_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = mem_req_o; mem_err_i = 1'b0; mem_rdata_i = '0;
      if (mem_req_o) begin
        if (mem_we_o) begin
          if (mem_addr_o == bad_wr) mem_err_i = 1'b1;
          else store[mem_addr_o] = mem_wdata_o;
        end else if (mem_addr_o == bad_rd) mem_err_i = 1'b1;
        else if (store.exists(mem_addr_o)) mem_rdata_i = store[mem_addr_o];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [38:0] mkva(input int v2, input int v1, input int v0, input int ofs);
    return {9'(v2), 9'(v1), 9'(v0), 12'(ofs)};
  endfunction

  function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [7:0] at);
    return {10'h0, ppn, 2'b00, at};
  endfunction

  function automatic logic [55:0] ent(input logic [38:0] va, input int l);
    logic [43:0] tbl;
    tbl = 44'h100 + 44'(2 - l);
    return {tbl, 12'h0} + 56'(va[12 + 9*l +: 9]) * 56'd8;
  endfunction

  task automatic build(input logic [38:0] va, input int leaf_lvl,
                       input logic [63:0] leaf, input logic [7:0] pat);
    store.delete();
    bad_rd = '1; bad_wr = '1;
    for (int l = 2; l > leaf_lvl; l--)
      store[ent(va, l)] = mkpte(44'h100 + 44'(3 - l), pat);
    store[ent(va, leaf_lvl)] = leaf;
  endtask

  task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic usr,
                      input logic mx, input logic sm, input logic up, input bit poke,
                      output int cyc);
    @(negedge clk);
    vaddr_i = va; acc_i = acc; user_i = usr; mxr_i = mx; sum_i = sm;
    upd_en_i = up; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; cyc = 1;
    if (poke) begin vaddr_i = ~va; start_i = 1'b1; end
    while (!done_o && cyc < 50) begin
      @(negedge clk); start_i = 1'b0; cyc++;
    end
  endtask

  logic [38:0] va0;
  initial va0 = mkva(1, 2, 3, 12'h123);

  task automatic t_reset;
    chk("R10 reset done", 64'(done_o), 0);
    chk("R10 reset req", 64'(mem_req_o), 0);
    chk("R10 reset fault", 64'(fault_o), 0);
  endtask

  task automatic t_page4k;
    int c;
    build(va0, 0, mkpte(44'h5555, V|R|W|A|D), V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R1 4k cycles", 64'(c), 4);
    chk("R1 4k pte_addr", 64'(pte_addr_o), 64'h102018);
    chk("R6 4k paddr", 64'(paddr_o), 64'h5555123);
    chk("R6 4k level", 64'(level_o), 0);
    chk("R10 4k fault", 64'(fault_o), 0);
    chk("R7 4k global", 64'(global_o), 0);
    chk("R1 4k pte", pte_o, mkpte(44'h5555, V|R|W|A|D));
  endtask

  task automatic t_super;
    int c;
    logic [38:0] va;
    va = mkva(1, 2, 3, 12'h456);
    build(va, 1, mkpte(44'h400, V|R|W|A|D), V);
    walk(va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R6 2m cycles", 64'(c), 3);
    chk("R6 2m paddr", 64'(paddr_o), 64'h403456);
    chk("R6 2m level", 64'(level_o), 1);
    chk("R1 2m pte_addr", 64'(pte_addr_o), 64'h101010);
    va = mkva(1, 2, 3, 12'h789);
    build(va, 2, mkpte(44'h40000, V|R|A|D), V);
    walk(va, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R6 1g cycles", 64'(c), 2);
    chk("R6 1g paddr", 64'(paddr_o), 64'h40403789);
    chk("R6 1g level", 64'(level_o), 2);
    build(va, 2, mkpte(44'h40001, V|R|A|D), V);
    walk(va, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R6 1g misaligned err", 64'(err_o), 4);
    chk("R6 1g misaligned fault", 64'(fault_o), 1);
  endtask

  task automatic t_invalid;
    int c;
    build(va0, 2, mkpte(44'h7, R|W|A|D), V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R3 not valid err", 64'(err_o), 2);
    chk("R3 not valid cycles", 64'(c), 2);
    build(va0, 1, mkpte(44'h7, V|W|A|D), V);
    walk(va0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R3 write-no-read err", 64'(err_o), 2);
    chk("R3 write-no-read cycles", 64'(c), 3);
  endtask

  task automatic t_ptr_l0;
    int c;
    build(va0, 0, mkpte(44'h103, V), V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R4 pointer at level0 err", 64'(err_o), 2);
    chk("R4 pointer at level0 cycles", 64'(c), 4);
  endtask

  task automatic t_memerr;
    int c;
    build(va0, 0, mkpte(44'h5555, V|R|A|D), V);
    bad_rd = ent(va0, 1);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R2 read error err", 64'(err_o), 1);
    chk("R2 read error cycles", 64'(c), 3);
  endtask

  task automatic perm_case(input string tag, input logic [7:0] at, input logic [1:0] acc,
                           input logic usr, input logic mx, input logic sm, input logic [2:0] e);
    int c;
    build(va0, 0, mkpte(44'h5555, at | V | A | D), V);
    walk(va0, acc, usr, mx, sm, 1'b0, 1'b0, c);
    chk(tag, 64'(err_o), 64'(e));
  endtask

  task automatic t_perm;
    perm_case("R5 user read non-user page", R, 2'd0, 1'b1, 1'b0, 1'b0, 3);
    perm_case("R5 user read user page", R|U, 2'd0, 1'b1, 1'b0, 1'b0, 0);
    perm_case("R5 sup read user page no sum", R|U, 2'd0, 1'b0, 1'b0, 1'b0, 3);
    perm_case("R5 sup read user page sum", R|U, 2'd0, 1'b0, 1'b0, 1'b1, 0);
    perm_case("R5 sup fetch user page sum", X|U, 2'd3, 1'b0, 1'b0, 1'b1, 3);
    perm_case("R5 exec-only read no mxr", X|U, 2'd0, 1'b1, 1'b0, 1'b0, 3);
    perm_case("R5 exec-only read mxr", X|U, 2'd0, 1'b1, 1'b1, 1'b0, 0);
    perm_case("R5 write read-only page", R, 2'd1, 1'b0, 1'b0, 1'b0, 3);
    perm_case("R5 rw on write page", R|W, 2'd2, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_update;
    int c;
    logic [63:0] lf;
    lf = mkpte(44'h5555, V|R|W);
    build(va0, 0, lf, V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R8 A clear disabled err", 64'(err_o), 5);
    chk("R8 A clear disabled cycles", 64'(c), 4);
    chk("R8 no write when disabled", store[ent(va0, 0)], lf);
    build(va0, 0, mkpte(44'h5555, V|R|W|A), V);
    walk(va0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R8 D clear on write err", 64'(err_o), 5);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R8 D clear on read err", 64'(err_o), 0);
    build(va0, 0, lf, V);
    walk(va0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, c);
    chk("R9 write-back cycles", 64'(c), 5);
    chk("R9 write-back err", 64'(err_o), 0);
    chk("R9 write-back memory", store[ent(va0, 0)], lf | 64'(A|D));
    chk("R9 write-back pte_o", pte_o, lf | 64'(A|D));
    build(va0, 0, lf, V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, c);
    chk("R9 read sets only A", store[ent(va0, 0)], lf | 64'(A));
    build(va0, 0, lf, V);
    bad_wr = ent(va0, 0);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, c);
    chk("R9 write error err", 64'(err_o), 1);
    chk("R9 write error cycles", 64'(c), 5);
  endtask

  task automatic t_global;
    int c;
    build(va0, 0, mkpte(44'h5555, V|R|A|D), V|G);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R7 global from pointers", 64'(global_o), 1);
    build(va0, 0, mkpte(44'h5555, V|R|A|D|G), V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    chk("R7 global from leaf", 64'(global_o), 1);
  endtask

  task automatic t_busy;
    int c;
    build(va0, 0, mkpte(44'h5555, V|R|A|D), V);
    walk(va0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, c);
    chk("R10 start while busy cycles", 64'(c), 4);
    chk("R10 start while busy paddr", 64'(paddr_o), 64'h5555123);
    @(negedge clk);
    chk("R10 done one cycle", 64'(done_o), 0);
    chk("R10 no second walk", 64'(mem_req_o), 0);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; vaddr_i = '0; acc_i = '0; user_i = 1'b0;
    mxr_i = 1'b0; sum_i = 1'b0; upd_en_i = 1'b0; root_ppn_i = 44'h100;
    bad_rd = '1; bad_wr = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_page4k();
    t_super();
    t_invalid();
    t_ptr_l0();
    t_memerr();
    t_perm();
    t_update();
    t_global();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule